// File: doc/BRIEF.md
# Slicing-by-4 CRC-32 Engine

This block keeps a running 32-bit reflected CRC and folds in one 32-bit data word per clock. The word is XORed into the current remainder and split into four bytes. Each byte indexes its own 256-entry lookup table, and the four table outputs are XORed to form the new remainder. The four tables differ in weight: the table for byte lane k gives the single-byte remainder pushed through 3-k further zero bytes. All table contents are computed during elaboration from the polynomial parameter.

A message is sent as a run of words. Byte lane 0 (bits 7:0) is the first byte on the wire. The first word of a message carries a `start` flag that presets the remainder to all ones. A final word that holds only one to three bytes is finished in the same cycle by a chain of single-table byte steps. The reported CRC is the remainder inverted, so it can be appended to the message directly. The result is identical to a bit-serial reflected CRC for any message length.

Top module: `crc_s4_engine`

## Requirements
- R1: While `rst_n` is low, and on the cycle after it is released, the internal remainder equals INIT (all ones), so `crc_out` equals INIT ^ XOROUT (0 with the defaults).
- R2: `start` high with `in_valid` low presets the remainder to INIT. `crc_out` reads INIT ^ XOROUT on the next cycle, whatever came before.
- R3: With `in_valid` and `start` both low, `crc_out` does not change, whatever `in_data` and `in_last_bytes` carry.
- R4: `in_valid` with `in_last_bytes` = 0 folds all four bytes of `in_data` into the remainder, lane 0 (bits 7:0) first and lane 3 (bits 31:24) last. A word equal to the current remainder brings the remainder to zero.
- R5: `in_valid` with `in_last_bytes` = n (1, 2 or 3) folds only lanes 0 to n-1, in the same order. The bytes in the higher lanes have no effect.
- R6: `start` high together with `in_valid` treats the word as the first word of a new message, folded into INIT rather than into the previous remainder.
- R7: After the words of a message have been folded in, `crc_out` equals the reflected CRC-32 of the message (polynomial 0xEDB88320, preset all ones, final inversion). The message "123456789" gives 0xCBF43926.
- R8: An update shows on `crc_out` exactly one clock after the cycle in which `in_valid` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Preset the remainder; with `in_valid`, marks the first word of a message |
| in_valid | input | 1 | `in_data` carries a word to fold in this cycle |
| in_data | input | 32 | Data word, lane 0 (bits 7:0) first on the wire |
| in_last_bytes | input | 2 | 0 = full word; 1..3 = only that many low lanes are valid |
| crc_out | output | 32 | Running CRC, inverted remainder |

## Verification
Messages of every length from 0 to 20 bytes are sent with three byte patterns: a ramp, all ones and all zeros. After each word the output is compared with a bit-serial model, so the four lane weights are checked against one another and the tail chain is checked for each residue of length modulo 4. The unused upper lanes of a final partial word are filled with non-zero bytes, which shows whether they leak into the result. Every message begins with `start` after the previous one, so a preset that fails to replace the old remainder shows up. Idle cycles with changing data confirm that the output holds.

// File: rtl/crc_s4_pkg.sv
package crc_s4_pkg;

  // One reflected byte shift with a zero input byte: eight bit steps of the division.
  function automatic logic [31:0] zero_byte_shift(logic [31:0] rem, logic [31:0] poly);
    logic [31:0] r;
    r = rem;
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

  // Entry idx of the lane table with weight k: the remainder of the one-byte
  // message idx, followed by k further zero bytes.
  function automatic logic [31:0] lane_entry(int k, logic [7:0] idx, logic [31:0] poly);
    logic [31:0] r;
    r = zero_byte_shift({24'd0, idx}, poly);
    for (int z = 0; z < k; z++) begin
      r = zero_byte_shift(r, poly);
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_s4_lane.sv
module crc_s4_lane #(
  parameter logic [31:0] POLY   = 32'hEDB88320,
  parameter int          WEIGHT = 0
) (
  input  logic [7:0]  idx,
  output logic [31:0] val
);
  import crc_s4_pkg::*;

  localparam int ENTRIES = 256;

  logic [31:0] rom [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam logic [31:0] ENT = lane_entry(WEIGHT, 8'(i), POLY);
    assign rom[i] = ENT;
  end

  assign val = rom[idx];
endmodule

// File: rtl/crc_s4_word.sv
module crc_s4_word #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic [31:0] rem,
  input  logic [31:0] data,
  output logic [31:0] nxt
);
  localparam int LANES = 4;

  logic [31:0] mixed;
  logic [31:0] part [LANES];

  assign mixed = rem ^ data;

  // Lane 0 is oldest on the wire, so it needs the most extra zero-byte weight.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    crc_s4_lane #(.POLY(POLY), .WEIGHT(LANES - 1 - k)) u_lane (
      .idx (mixed[8*k +: 8]),
      .val (part[k])
    );
  end

  assign nxt = part[0] ^ part[1] ^ part[2] ^ part[3];
endmodule

// File: rtl/crc_s4_tail.sv
module crc_s4_tail #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic [31:0] rem,
  input  logic [31:0] data,
  input  logic [1:0]  count,
  output logic [31:0] nxt
);
  localparam int STEPS = 3;

  logic [31:0] chain [STEPS + 1];
  logic [31:0] hit   [STEPS];

  assign chain[0] = rem;

  for (genvar j = 0; j < STEPS; j++) begin : g_step
    crc_s4_lane #(.POLY(POLY), .WEIGHT(0)) u_lane (
      .idx (chain[j][7:0] ^ data[8*j +: 8]),
      .val (hit[j])
    );
    assign chain[j+1] = (chain[j] >> 8) ^ hit[j];
  end

  assign nxt = chain[count];
endmodule

// File: rtl/crc_s4_engine.sv
module crc_s4_engine #(
  parameter logic [31:0] POLY   = 32'hEDB88320,
  parameter logic [31:0] INIT   = 32'hFFFFFFFF,
  parameter logic [31:0] XOROUT = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic [1:0]  in_last_bytes,
  output logic [31:0] crc_out
);
  logic [31:0] rem_q;
  logic [31:0] base_rem;
  logic [31:0] word_nxt;
  logic [31:0] tail_nxt;
  logic [31:0] rem_d;
  logic        word_fire;
  logic        tail_fire;

  assign base_rem  = start ? INIT : rem_q;
  assign word_fire = in_valid && (in_last_bytes == 2'd0);
  assign tail_fire = in_valid && (in_last_bytes != 2'd0);

  crc_s4_word #(.POLY(POLY)) u_word (
    .rem  (base_rem),
    .data (in_data),
    .nxt  (word_nxt)
  );

  crc_s4_tail #(.POLY(POLY)) u_tail (
    .rem   (base_rem),
    .data  (in_data),
    .count (in_last_bytes),
    .nxt   (tail_nxt)
  );

  always_comb begin
    if (word_fire)      rem_d = word_nxt;
    else if (tail_fire) rem_d = tail_nxt;
    else                rem_d = base_rem;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= INIT;
    else        rem_q <= rem_d;
  end

  assign crc_out = rem_q ^ XOROUT;
endmodule

// File: rtl/crc_s4_checker.sv
module crc_s4_checker #(
  parameter logic [31:0] INIT   = 32'hFFFFFFFF,
  parameter logic [31:0] XOROUT = 32'hFFFFFFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic [1:0]  in_last_bytes,
  input logic [31:0] crc_out
);
  // R1
  reset_value_chk: assert property (@(posedge clk)
    !rst_n |=> crc_out == (INIT ^ XOROUT));

  // R2
  start_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> crc_out == (INIT ^ XOROUT));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !in_valid) |=> $stable(crc_out));

  // R4
  word_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !start && in_last_bytes == 2'd0 && in_data == (crc_out ^ XOROUT))
      |=> crc_out == XOROUT);
endmodule

bind crc_s4_engine crc_s4_checker #(.INIT(INIT), .XOROUT(XOROUT)) u_crc_s4_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .in_valid      (in_valid),
  .in_data       (in_data),
  .in_last_bytes (in_last_bytes),
  .crc_out       (crc_out)
);

// File: tb/test_crc_s4_engine.sv
module test_crc_s4_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'd0;
  logic [1:0]  in_last_bytes = 2'd0;
  logic [31:0] crc_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] msg [64];

  always #2 clk = ~clk;

  crc_s4_engine i_crc_s4_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_last_bytes (in_last_bytes),
    .crc_out       (crc_out)
  );

  // Bit-serial reflected reference, one input bit at a time.
  function automatic logic [31:0] ser_byte(logic [31:0] s, logic [7:0] b);
    logic [31:0] r;
    r = s;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(logic st, logic vld, logic [31:0] d, logic [1:0] nb);
    start = st; in_valid = vld; in_data = d; in_last_bytes = nb;
    @(posedge clk); #1;
    start = 1'b0; in_valid = 1'b0; in_data = 32'h5A5A_C3C3; in_last_bytes = 2'd2;
  endtask

  // Sends msg[0..len-1]; compares after every word with the serial model.
  task automatic send_msg(int len, string req);
    logic [31:0] s;
    s = 32'hFFFFFFFF;
    if (len == 0) begin
      drive(1'b1, 1'b0, 32'hDEAD_BEEF, 2'd0);
      check("R2 empty message preset", crc_out, 32'h0);
    end
    for (int w = 0; w * 4 < len; w++) begin
      logic [31:0] d;
      int nb;
      nb = (len - 4 * w >= 4) ? 4 : (len - 4 * w);
      for (int j = 0; j < 4; j++) begin
        if (j < nb) begin
          d[8*j +: 8] = msg[4*w + j];
          s = ser_byte(s, msg[4*w + j]);
        end else begin
          d[8*j +: 8] = 8'hA5 ^ 8'(j * 17);  // R5: junk in unused lanes
        end
      end
      drive(w == 0, 1'b1, d, 2'(nb % 4));
      check(req, crc_out, ~s);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk); #1;
    check("R1 reset value", crc_out, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", crc_out, 32'h0);

    // R7 check value "123456789"
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    send_msg(9, "R7 check value");
    check("R7 check value final", crc_out, 32'hCBF43926);

    // R3 idle hold with changing data
    held = crc_out;
    for (int i = 0; i < 4; i++) begin
      in_data = 32'h1234_5678 * (i + 3); in_last_bytes = 2'(i);
      @(posedge clk); #1;
      check("R3 idle hold", crc_out, held);
    end

    // R4 word equal to remainder cancels it (R8: one cycle later)
    drive(1'b0, 1'b1, ~crc_out, 2'd0);
    check("R4 cancel word", crc_out, 32'hFFFFFFFF);

    // R2 start alone after a dirty state
    drive(1'b1, 1'b0, 32'h0BAD_F00D, 2'd1);
    check("R2 preset", crc_out, 32'h0);

    // R4 R5 R6 R7 R8: sweep lengths and patterns; start follows prior messages
    for (int p = 0; p < 3; p++) begin
      for (int len = 0; len <= 20; len++) begin
        for (int i = 0; i < 64; i++) begin
          case (p)
            0:       msg[i] = 8'(i * 37 + 11);
            1:       msg[i] = 8'hFF;
            default: msg[i] = 8'h00;
          endcase
        end
        send_msg(len, "R4 R5 R6 R7 sweep");
      end
    end

    // R5 single trailing byte alone vs. serial model
    msg[0] = 8'h80;
    send_msg(1, "R5 single byte");
    check("R5 single byte value", crc_out, ~ser_byte(32'hFFFFFFFF, 8'h80));

    finish_run();
  end
endmodule